// File: doc/BRIEF.md
# Main Clock Loss Monitor

This block watches the main system clock from the always-running internal oscillator clock. It samples the main clock through a flop synchronizer in the oscillator domain. It counts oscillator cycles in which the synchronized level does not change. When that count reaches a fixed window and software has armed the monitor, the block drives an internal reset request for a fixed number of oscillator cycles. In the same cycle it sets a sticky reset-cause flag.

Every external reset disarms the monitor. Monitoring begins only when software writes a 1 to the arm bit during normal operation, and a later write of 0 does not disarm it. The cause flag is kept through the internal reset that the block itself raises. Only a software clear strobe or the external reset clears it.

Top module: `clock_loss_monitor`

## Requirements
- R1: When `ext_rst_n` is low at a rising `osc_clk` edge, `int_rst`, `arm_q` and `cause_flag` are all 0 after that edge.
- R2: A cycle with `arm_wr`=1 and `arm_wdata`=1 makes `arm_q`=1 after that edge. A write with `arm_wdata`=0 leaves `arm_q` unchanged, so once armed it stays 1 until an external reset.
- R3: While `arm_q` is 0, a stopped main clock never raises `int_rst`, however long it stays stopped.
- R4: While armed, the main clock is sampled through two flops plus one edge-detect flop. If its last level change comes just before rising edge k, `int_rst` is still 0 after edge k+6 and becomes 1 after edge k+7. That is four oscillator cycles with no edge seen.
- R5: `int_rst` stays 1 for exactly 8 oscillator cycles. If the main clock has resumed by the end of that period, `int_rst` returns to 0.
- R6: If the main clock is still absent when the 8-cycle period ends, `int_rst` stays 1 with no gap and a new 8-cycle period begins.
- R7: `cause_flag` becomes 1 in the same cycle that `int_rst` starts a period. It stays 1 after `int_rst` drops, and `cause_clr`=1 clears it after the next edge. A start and a clear in the same cycle leave it set.
- R8: The no-edge counter is held at zero while disarmed. When the monitor is armed while the main clock is already stopped, with `arm_q` first 1 after edge a, `int_rst` is 0 after edge a+4 and 1 after edge a+5.
- R9: While armed, a main clock that keeps toggling keeps `int_rst` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Internal oscillator clock; clocks all logic of the block |
| ext_rst_n | input | 1 | External reset, active low, sampled on `osc_clk` |
| main_clk | input | 1 | Monitored main clock, asynchronous to `osc_clk` |
| arm_wr | input | 1 | Software write strobe for the arm bit |
| arm_wdata | input | 1 | Value written with `arm_wr`; only 1 has an effect |
| cause_clr | input | 1 | Software strobe that clears the cause flag |
| int_rst | output | 1 | Internal reset request, active high |
| arm_q | output | 1 | Current arm bit |
| cause_flag | output | 1 | Sticky flag: a reset was raised by clock loss |

## Verification
Each result is due a fixed number of oscillator edges after its stimulus. A strobe shows on `arm_q` or `cause_flag` one edge later. A stop of the main clock raises `int_rst` seven edges after the last sampled transition, or five edges after arming when the clock is already stopped. A hold period lasts eight edges. The bench changes `main_clk` 2 ns after a rising edge and drives every strobe at a falling edge, so each transition falls before a known edge. Each expectation is queued with the exact cycle number at which it is due. The monitor compares it at the falling edge of that cycle, so every sample is taken where the output has settled.

// File: rtl/clm_pkg.sv
// Package: defaults and a width helper shared by the clock loss monitor.
// Assumes: counters are sized to hold the value of their limit itself.
package clm_pkg;

    parameter int unsigned CLM_DEF_SYNC_STAGES = 2;
    parameter int unsigned CLM_DEF_WINDOW      = 4;
    parameter int unsigned CLM_DEF_HOLD        = 8;

    // Bits needed to hold values 0..limit.
    function automatic int unsigned clm_cnt_width(input int unsigned limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/clm_sync.sv
// Module: clm_sync
// Brings an asynchronous level into the clk domain through a flop chain.
// Assumes: STAGES >= 2; synchronous active-low reset clears the chain.
module clm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage: capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                // Later stages: pass the level along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/clm_stop_det.sv
// Module: clm_stop_det
// Counts oscillator cycles with no main clock edge; flags a stop at WINDOW.
// Assumes: counter is held at zero whenever enable is 0, so arming starts
// from a clean count.
module clm_stop_det
    import clm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = CLM_DEF_SYNC_STAGES,
    parameter int unsigned WINDOW      = CLM_DEF_WINDOW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic main_clk,
    output logic stop
);

    localparam int unsigned CW = clm_cnt_width(WINDOW);
    localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

    logic          sync_lvl;
    logic          last_lvl_q;
    logic          edge_seen;
    logic [CW-1:0] quiet_cnt_q;

    clm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (main_clk),
        .q       (sync_lvl)
    );

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_lvl_q <= 1'b0;
        else        last_lvl_q <= sync_lvl;
    end

    assign edge_seen = sync_lvl ^ last_lvl_q;

    // Count quiet cycles; clear on any edge or while disarmed; saturate.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)       quiet_cnt_q <= '0;
        else if (edge_seen)          quiet_cnt_q <= '0;
        else if (quiet_cnt_q != LIMIT) quiet_cnt_q <= quiet_cnt_q + 1'b1;
    end

    assign stop = (quiet_cnt_q == LIMIT);

endmodule

// File: rtl/clm_ctrl.sv
// Module: clm_ctrl
// Holds the arm bit, the sticky cause flag and the reset-hold timer.
// Assumes: stop is already in the clk domain; only rst_n clears arm.
module clm_ctrl
    import clm_pkg::*;
#(
    parameter int unsigned HOLD = CLM_DEF_HOLD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_wr,
    input  logic arm_wdata,
    input  logic cause_clr,
    input  logic stop,
    output logic arm_q,
    output logic int_rst,
    output logic cause_flag
);

    localparam int unsigned HW = clm_cnt_width(HOLD);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

    logic [HW-1:0] hold_q;
    logic          period_end;
    logic          start;

    assign period_end = (hold_q == '0) || (hold_q == HW'(1));
    assign start      = stop && arm_q && period_end;

    // Arm bit: set by a write of 1, writes of 0 ignored.
    always_ff @(posedge clk) begin
        if (!rst_n)                  arm_q <= 1'b0;
        else if (arm_wr && arm_wdata) arm_q <= 1'b1;
    end

    // Hold timer: load on a start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             hold_q <= '0;
        else if (start)         hold_q <= HOLD_V;
        else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
    end

    // Cause flag: a start sets it and wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         cause_flag <= 1'b0;
        else if (start)     cause_flag <= 1'b1;
        else if (cause_clr) cause_flag <= 1'b0;
    end

    assign int_rst = (hold_q != '0);

endmodule

// File: rtl/clock_loss_monitor.sv
// Module: clock_loss_monitor
// Top: raises an internal reset when the armed monitor sees the main clock
// stop for WINDOW oscillator cycles, and records the cause.
// Assumes: osc_clk always runs; ext_rst_n is synchronous to osc_clk.
module clock_loss_monitor
    import clm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = CLM_DEF_SYNC_STAGES,
    parameter int unsigned WINDOW      = CLM_DEF_WINDOW,
    parameter int unsigned HOLD_CYCLES = CLM_DEF_HOLD
) (
    input  logic osc_clk,
    input  logic ext_rst_n,
    input  logic main_clk,
    input  logic arm_wr,
    input  logic arm_wdata,
    input  logic cause_clr,
    output logic int_rst,
    output logic arm_q,
    output logic cause_flag
);

    logic stop;

    clm_stop_det #(
        .SYNC_STAGES (SYNC_STAGES),
        .WINDOW      (WINDOW)
    ) u_det (
        .clk      (osc_clk),
        .rst_n    (ext_rst_n),
        .enable   (arm_q),
        .main_clk (main_clk),
        .stop     (stop)
    );

    clm_ctrl #(
        .HOLD (HOLD_CYCLES)
    ) u_ctrl (
        .clk        (osc_clk),
        .rst_n      (ext_rst_n),
        .arm_wr     (arm_wr),
        .arm_wdata  (arm_wdata),
        .cause_clr  (cause_clr),
        .stop       (stop),
        .arm_q      (arm_q),
        .int_rst    (int_rst),
        .cause_flag (cause_flag)
    );

endmodule

// File: rtl/clm_checker.sv
// Module: clm_checker
// Port-level properties of clock_loss_monitor, attached with bind.
// Assumes: main_clk changes away from osc_clk rising edges.
module clm_checker #(
    parameter int unsigned HOLD_CYCLES = 8
) (
    input logic osc_clk,
    input logic ext_rst_n,
    input logic main_clk,
    input logic int_rst,
    input logic arm_q,
    input logic cause_flag
);

    logic        rst_seen_q = 1'b0;
    int unsigned run_q      = 0;

    // Note that the previous edge sampled reset asserted.
    always @(posedge osc_clk) rst_seen_q <= !ext_rst_n;

    // Length of the current run of int_rst high samples.
    always @(posedge osc_clk) run_q <= int_rst ? run_q + 1 : 0;

    // R1: outputs cleared after a reset edge.
    always @(posedge osc_clk) begin
        if (rst_seen_q) begin
            a_r1_reset_clears: assert (!int_rst && !arm_q && !cause_flag);
        end
    end

    a_r2_arm_sticky: assert property (@(posedge osc_clk) disable iff (!ext_rst_n)
        arm_q |=> arm_q);

    a_r3_idle_when_disarmed: assert property (@(posedge osc_clk) disable iff (!ext_rst_n)
        (!arm_q && !int_rst) |=> !int_rst);

    a_r4_rise_needs_quiet: assert property (@(posedge osc_clk) disable iff (!ext_rst_n)
        $rose(int_rst) |-> ($stable(main_clk) && (main_clk == $past(main_clk, 3))));

    a_r5_hold_length: assert property (@(posedge osc_clk) disable iff (!ext_rst_n)
        ($fell(int_rst) && $past(ext_rst_n)) |-> ((run_q != 0) && ((run_q % HOLD_CYCLES) == 0)));

    a_r7_cause_with_reset: assert property (@(posedge osc_clk) disable iff (!ext_rst_n)
        $rose(int_rst) |-> cause_flag);

endmodule

bind clock_loss_monitor clm_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_clm_checker (
    .osc_clk    (osc_clk),
    .ext_rst_n  (ext_rst_n),
    .main_clk   (main_clk),
    .int_rst    (int_rst),
    .arm_q      (arm_q),
    .cause_flag (cause_flag)
);

// File: tb/test_clock_loss_monitor.sv
// Bench: scoreboard of (due cycle, output, value) items checked at falling edges.
module test_clock_loss_monitor;

    localparam int SIG_RST = 0;
    localparam int SIG_ARM = 1;
    localparam int SIG_CAU = 2;

    typedef struct {
        int    due;
        int    sig;
        bit    val;
        string req;
    } exp_t;

    logic osc_clk   = 1'b0;
    logic ext_rst_n = 1'b0;
    logic main_clk  = 1'b0;
    logic arm_wr    = 1'b0;
    logic arm_wdata = 1'b0;
    logic cause_clr = 1'b0;
    logic int_rst;
    logic arm_q;
    logic cause_flag;

    bit   run_main = 1'b1;
    int   cyc      = 0;
    int   checks   = 0;
    int   fails    = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];
    exp_t cur;
    logic act;

    clock_loss_monitor i_clock_loss_monitor (
        .osc_clk    (osc_clk),
        .ext_rst_n  (ext_rst_n),
        .main_clk   (main_clk),
        .arm_wr     (arm_wr),
        .arm_wdata  (arm_wdata),
        .cause_clr  (cause_clr),
        .int_rst    (int_rst),
        .arm_q      (arm_q),
        .cause_flag (cause_flag)
    );

    always #5 osc_clk = ~osc_clk;

    // Main clock: toggles 2 ns after each oscillator rise while running.
    always @(posedge osc_clk) begin
        #2;
        if (run_main) main_clk = ~main_clk;
    end

    always @(posedge osc_clk) cyc <= cyc + 1;

    task automatic step(input int n);
        repeat (n) @(negedge osc_clk);
    endtask

    task automatic expect_at(input int due, input int sig, input bit val, input string req);
        exp_t e;
        e.due = due; e.sig = sig; e.val = val; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: pop every item due in this cycle and compare.
    always @(negedge osc_clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            cur = sb_q.pop_front();
            case (cur.sig)
                SIG_RST: act = int_rst;
                SIG_ARM: act = arm_q;
                default: act = cause_flag;
            endcase
            checks++;
            if (cur.due != cyc || act !== cur.val) begin
                fails++;
                $display("FAIL %s sig%0d cycle %0d (due %0d): actual %b expected %b",
                         cur.req, cur.sig, cyc, cur.due, act, cur.val);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c;
        step(2);
        // R1: reset state
        c = cyc;
        expect_at(c + 1, SIG_RST, 1'b0, "R1");
        expect_at(c + 1, SIG_ARM, 1'b0, "R1");
        expect_at(c + 1, SIG_CAU, 1'b0, "R1");
        step(2);
        ext_rst_n = 1'b1;
        step(4);

        // R3: stopped clock while disarmed
        c = cyc;
        run_main = 1'b0;
        expect_at(c + 10, SIG_RST, 1'b0, "R3");
        expect_at(c + 20, SIG_RST, 1'b0, "R3");
        step(21);
        run_main = 1'b1;
        step(6);

        // R2: a write of 0 while disarmed has no effect, then arm
        c = cyc;
        arm_wr = 1'b1; arm_wdata = 1'b0;
        expect_at(c + 2, SIG_ARM, 1'b0, "R2");
        step(1); arm_wr = 1'b0; step(2);
        c = cyc;
        arm_wr = 1'b1; arm_wdata = 1'b1;
        expect_at(c + 1, SIG_ARM, 1'b1, "R2");
        step(1); arm_wr = 1'b0; step(2);
        // R2: a write of 0 is ignored; R9: running clock keeps reset low
        c = cyc;
        arm_wr = 1'b1; arm_wdata = 1'b0;
        expect_at(c + 2, SIG_ARM, 1'b1, "R2");
        expect_at(c + 10, SIG_RST, 1'b0, "R9");
        expect_at(c + 20, SIG_RST, 1'b0, "R9");
        step(1); arm_wr = 1'b0; step(21);

        // R4/R5/R7: stop, detect, restart inside the hold period
        c = cyc;
        run_main = 1'b0;
        expect_at(c + 7, SIG_RST, 1'b0, "R4");
        expect_at(c + 8, SIG_RST, 1'b1, "R4");
        expect_at(c + 8, SIG_CAU, 1'b1, "R7");
        expect_at(c + 15, SIG_RST, 1'b1, "R5");
        expect_at(c + 16, SIG_RST, 1'b0, "R5");
        expect_at(c + 16, SIG_ARM, 1'b1, "R2");
        expect_at(c + 16, SIG_CAU, 1'b1, "R7");
        step(9);
        run_main = 1'b1;
        step(10);

        // R7: software clear
        c = cyc;
        cause_clr = 1'b1;
        expect_at(c + 1, SIG_CAU, 1'b0, "R7");
        step(1); cause_clr = 1'b0; step(2);

        // R6: clock stays stopped, reset held across periods
        c = cyc;
        run_main = 1'b0;
        expect_at(c + 8, SIG_RST, 1'b1, "R6");
        expect_at(c + 15, SIG_RST, 1'b1, "R6");
        expect_at(c + 16, SIG_RST, 1'b1, "R6");
        expect_at(c + 24, SIG_RST, 1'b1, "R6");
        step(26);

        // R1: external reset during an active hold
        c = cyc;
        ext_rst_n = 1'b0;
        expect_at(c + 1, SIG_RST, 1'b0, "R1");
        expect_at(c + 1, SIG_ARM, 1'b0, "R1");
        expect_at(c + 1, SIG_CAU, 1'b0, "R1");
        step(2);
        ext_rst_n = 1'b1;
        expect_at(c + 14, SIG_RST, 1'b0, "R3");
        step(14);

        // R8: arm while the main clock is already stopped
        c = cyc;
        arm_wr = 1'b1; arm_wdata = 1'b1;
        expect_at(c + 5, SIG_RST, 1'b0, "R8");
        expect_at(c + 6, SIG_RST, 1'b1, "R8");
        expect_at(c + 6, SIG_CAU, 1'b1, "R7");
        step(1); arm_wr = 1'b0; step(8);

        run_main = 1'b1;
        ext_rst_n = 1'b0;
        step(3);
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        finish_run();
    end

endmodule